// File: doc/BRIEF.md
# Receive Enable Calibration Sequencer

This block runs the timing search that places one byte lane's receive-enable window at the start of the strobe preamble. It keeps a three-level delay setting: a coarse count, a quarter-step medium count and a fine tap count from 0 to 14. Fifteen taps make one medium step, four medium steps make one coarse step. A separate interpolator code is forced to fixed values at two points of the search. For each sample it pulses an active-low probe reset, waits a programmable number of cycles, issues a read and takes the strobe bit returned with the read response.

Software or a training controller starts the block with a lane number and a starting coarse value. The starting medium value comes from the lane, which spreads the lanes over the four quarter positions. The block walks the setting forward until the strobe is low. It finds a low-to-high edge with medium steps and then with tap steps. It checks that the strobe is high one quarter step later and backs off whole coarse steps until the strobe is low again. It then finds the edge a second time. The final setting stays on the delay outputs. Done or fail is raised at the end and held until the next start.

Top module: `rcv_cal_seq`

## Requirements
- R1: After reset, busy, done, fail, rd_req and every rcv_en bit are 0, and probe_rst_n is 1.
- R2: A start pulse while idle loads coarse from init_coarse, medium from the top two bits of start_lane (lane*4/NUM_LANES), tap 0 and interpolator 0. It sets busy and makes rcv_en one-hot at bit start_lane for the whole run.
- R3: Each sample drives probe_rst_n low for exactly rst_wait+1 cycles, then high for rst_wait+1 cycles, then raises rd_req and holds it until rd_valid. rd_dqs is taken in the rd_valid cycle, with 1 meaning high.
- R4: The delay outputs are stable from the start of a sample until the response arrives. Each sample sees exactly the setting that the preceding steps produced. A medium increment from 3 moves to medium 0 of the next coarse, and a medium decrement from 0 moves to medium 3 of the previous coarse.
- R5: Low search: while a sample reads high, medium is incremented and the sample repeated. When a sample reads low, medium is incremented once more.
- R6: Edge search: medium is incremented between samples until one reads high, then decremented once. Tap is then incremented before every sample until one reads high. At least one tap step is always taken, and tap 14 rolls to tap 0 with a medium increment.
- R7: After the first edge, tap is decremented once (tap 0 rolls to 14 with a medium decrement) and the interpolator is set to 3. Medium is then incremented once and the sample must read high. A low sample ends the run with fail.
- R8: Coarse back-off: while a sample reads high, coarse is decremented and the sample repeated. A high sample at coarse 0 ends the run with fail.
- R9: After the back-off reads low, the edge search runs again. Tap is then decremented once and the interpolator set to 7. Done rises, busy falls and all rcv_en bits clear.
- R10: A refused step ends the run with fail, leaves the setting unchanged, keeps rcv_en asserted and issues no further sample. Refused steps are a medium increment past coarse 15 medium 3, and a medium decrement below coarse 0 medium 0.
- R11: A start pulse while busy has no effect on the lane, the samples or the outcome.
- R12: Done and fail are never high together and hold their value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calibration run (accepted when idle) |
| start_lane | input | LANE_W | Lane to calibrate |
| init_coarse | input | CRS_W | Starting coarse value |
| rst_wait | input | WAIT_W | Probe reset wait, in cycles minus one |
| probe_rst_n | output | 1 | Active-low strobe probe reset |
| rd_req | output | 1 | Read request, held until rd_valid |
| rd_valid | input | 1 | Read response valid |
| rd_dqs | input | 1 | Captured strobe bit, valid with rd_valid |
| rcv_en | output | NUM_LANES | Receive enable per lane |
| dly_coarse | output | CRS_W | Coarse delay setting |
| dly_medium | output | 2 | Quarter-step delay setting |
| dly_tap | output | TAP_W | Fine tap setting (0 to TAP_MAX) |
| dly_pi | output | 3 | Interpolator code |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run succeeded |
| fail | output | 1 | Last run aborted |

## Verification
Every sample exposes the whole delay setting on the outputs when the read goes out. A wrong step, a missed roll-over or a wrong search phase therefore shows up at the next rd_req, one probe sequence (2*(rst_wait+1) cycles plus read latency) after the faulty step. A wrong branch on the strobe value, such as continuing after a failed preamble check, shows as an extra or a missing sample, or as a wrong done, fail or rcv_en value when busy falls. Errors in the reset-pulse counter show in the low and high phase lengths of probe_rst_n on the very first sample.

// File: rtl/rcv_cal_pkg.sv
package rcv_cal_pkg;

  typedef enum logic [2:0] {
    DC_NONE,
    DC_INC_MED,
    DC_DEC_MED,
    DC_INC_TAP,
    DC_DEC_TAP,
    DC_DEC_CRS
  } dly_cmd_e;

  typedef enum logic [1:0] {
    PB_IDLE,
    PB_RST_LO,
    PB_RST_HI,
    PB_READ
  } probe_st_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_LOW_SMP,
    S_LOW_STEP,
    S_ADV,
    S_MH_SMP,
    S_MH_STEP,
    S_MH_BACK,
    S_FT_STEP,
    S_FT_SMP,
    S_EDGE_END,
    S_PRE_STEP,
    S_PRE_SMP,
    S_CO_SMP,
    S_CO_STEP
  } cal_st_e;

endpackage

// File: rtl/rcv_delay_ctr.sv
module rcv_delay_ctr
  import rcv_cal_pkg::*;
#(
  parameter int CRS_W   = 4,
  parameter int TAP_MAX = 14,
  localparam int TAP_W  = $clog2(TAP_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CRS_W-1:0] load_crs,
  input  logic [1:0]       load_med,
  input  dly_cmd_e         cmd,
  input  logic             pi_set,
  input  logic [2:0]       pi_val,
  output logic             refuse,
  output logic [CRS_W-1:0] crs,
  output logic [1:0]       med,
  output logic [TAP_W-1:0] tap,
  output logic [2:0]       pi
);

  localparam logic [CRS_W-1:0] CRS_TOP = '1;
  localparam logic [TAP_W-1:0] TAP_TOP = TAP_W'(TAP_MAX);

  logic [CRS_W-1:0] crs_q, crs_n, up_crs, dn_crs;
  logic [1:0]       med_q, med_n, up_med, dn_med;
  logic [TAP_W-1:0] tap_q, tap_n;
  logic [2:0]       pi_q;
  logic             up_ok, dn_ok, upd;

  // quarter-step moves with carry into and borrow from coarse
  always_comb begin
    up_ok  = (med_q != 2'd3) || (crs_q != CRS_TOP);
    dn_ok  = (med_q != 2'd0) || (crs_q != '0);
    up_med = med_q + 2'd1;
    dn_med = med_q - 2'd1;
    up_crs = (med_q == 2'd3) ? crs_q + 1'b1 : crs_q;
    dn_crs = (med_q == 2'd0) ? crs_q - 1'b1 : crs_q;
  end

  always_comb begin
    crs_n  = crs_q;
    med_n  = med_q;
    tap_n  = tap_q;
    refuse = 1'b0;
    case (cmd)
      DC_INC_MED: begin
        refuse = !up_ok;
        crs_n  = up_crs;
        med_n  = up_med;
      end
      DC_DEC_MED: begin
        refuse = !dn_ok;
        crs_n  = dn_crs;
        med_n  = dn_med;
      end
      DC_INC_TAP: begin
        if (tap_q == TAP_TOP) begin
          refuse = !up_ok;
          crs_n  = up_crs;
          med_n  = up_med;
          tap_n  = '0;
        end else begin
          tap_n = tap_q + 1'b1;
        end
      end
      DC_DEC_TAP: begin
        if (tap_q == '0) begin
          refuse = !dn_ok;
          crs_n  = dn_crs;
          med_n  = dn_med;
          tap_n  = TAP_TOP;
        end else begin
          tap_n = tap_q - 1'b1;
        end
      end
      DC_DEC_CRS: begin
        refuse = (crs_q == '0);
        crs_n  = crs_q - 1'b1;
      end
      default: ;
    endcase
  end

  assign upd = (cmd != DC_NONE) && !refuse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crs_q <= '0;
      med_q <= '0;
      tap_q <= '0;
      pi_q  <= '0;
    end else if (load) begin
      crs_q <= load_crs;
      med_q <= load_med;
      tap_q <= '0;
      pi_q  <= '0;
    end else if (upd) begin
      crs_q <= crs_n;
      med_q <= med_n;
      tap_q <= tap_n;
      if (pi_set) pi_q <= pi_val;
    end
  end

  assign crs = crs_q;
  assign med = med_q;
  assign tap = tap_q;
  assign pi  = pi_q;

endmodule

// File: rtl/rcv_probe_seq.sv
module rcv_probe_seq
  import rcv_cal_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [WAIT_W-1:0] rst_wait,
  input  logic              rd_valid,
  input  logic              rd_dqs,
  output logic              probe_rst_n,
  output logic              rd_req,
  output logic              smp_done,
  output logic              smp_hi
);

  probe_st_e         st_q, st_n;
  logic [WAIT_W-1:0] cnt_q, cnt_n;
  logic              cap;
  logic              done_q, hi_q;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    cap   = 1'b0;
    case (st_q)
      PB_IDLE: begin
        if (go) begin
          st_n  = PB_RST_LO;
          cnt_n = '0;
        end
      end
      PB_RST_LO: begin
        if (cnt_q == rst_wait) begin
          st_n  = PB_RST_HI;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      PB_RST_HI: begin
        if (cnt_q == rst_wait) begin
          st_n  = PB_READ;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      PB_READ: begin
        if (rd_valid) begin
          st_n = PB_IDLE;
          cap  = 1'b1;
        end
      end
      default: st_n = PB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PB_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
      hi_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      done_q <= cap;
      if (cap) hi_q <= rd_dqs;
    end
  end

  assign probe_rst_n = (st_q != PB_RST_LO);
  assign rd_req      = (st_q == PB_READ);
  assign smp_done    = done_q;
  assign smp_hi      = hi_q;

endmodule

// File: rtl/rcv_cal_seq.sv
module rcv_cal_seq
  import rcv_cal_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int CRS_W     = 4,
  parameter int TAP_MAX   = 14,
  parameter int WAIT_W    = 8,
  localparam int LANE_W   = $clog2(NUM_LANES),
  localparam int TAP_W    = $clog2(TAP_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [LANE_W-1:0]    start_lane,
  input  logic [CRS_W-1:0]     init_coarse,
  input  logic [WAIT_W-1:0]    rst_wait,
  output logic                 probe_rst_n,
  output logic                 rd_req,
  input  logic                 rd_valid,
  input  logic                 rd_dqs,
  output logic [NUM_LANES-1:0] rcv_en,
  output logic [CRS_W-1:0]     dly_coarse,
  output logic [1:0]           dly_medium,
  output logic [TAP_W-1:0]     dly_tap,
  output logic [2:0]           dly_pi,
  output logic                 busy,
  output logic                 done,
  output logic                 fail
);

  cal_st_e              st_q, st_n;
  logic                 second_q, second_n;
  logic                 launched_q, launched_n;
  logic [NUM_LANES-1:0] rcv_en_q;
  logic                 done_q, fail_q;
  dly_cmd_e             cmd;
  logic                 pi_set, load, refuse;
  logic [2:0]           pi_val;
  logic                 fin_ok, fin_bad, smp_state;
  logic                 probe_go, smp_done, smp_hi;
  logic [1:0]           load_med;

  // lanes spread over the four quarter positions (NUM_LANES a power of two, >= 4)
  assign load_med = start_lane[LANE_W-1 -: 2];

  assign smp_state = (st_q == S_LOW_SMP) || (st_q == S_MH_SMP) || (st_q == S_FT_SMP) ||
                     (st_q == S_PRE_SMP) || (st_q == S_CO_SMP);
  assign probe_go   = smp_state && !launched_q;
  assign launched_n = smp_done ? 1'b0 : (probe_go ? 1'b1 : launched_q);

  always_comb begin
    st_n     = st_q;
    second_n = second_q;
    cmd      = DC_NONE;
    pi_set   = 1'b0;
    pi_val   = second_q ? 3'd7 : 3'd3;
    load     = 1'b0;
    fin_ok   = 1'b0;
    fin_bad  = 1'b0;
    case (st_q)
      S_IDLE: if (start) begin
        load     = 1'b1;
        second_n = 1'b0;
        st_n     = S_LOW_SMP;
      end
      S_LOW_SMP: if (smp_done) st_n = smp_hi ? S_LOW_STEP : S_ADV;
      S_LOW_STEP: begin
        cmd  = DC_INC_MED;
        st_n = S_LOW_SMP;
      end
      S_ADV: begin
        cmd  = DC_INC_MED;
        st_n = S_MH_SMP;
      end
      S_MH_SMP: if (smp_done) st_n = smp_hi ? S_MH_BACK : S_MH_STEP;
      S_MH_STEP: begin
        cmd  = DC_INC_MED;
        st_n = S_MH_SMP;
      end
      S_MH_BACK: begin
        cmd  = DC_DEC_MED;
        st_n = S_FT_STEP;
      end
      S_FT_STEP: begin
        cmd  = DC_INC_TAP;
        st_n = S_FT_SMP;
      end
      S_FT_SMP: if (smp_done) st_n = smp_hi ? S_EDGE_END : S_FT_STEP;
      S_EDGE_END: begin
        cmd    = DC_DEC_TAP;
        pi_set = 1'b1;
        st_n   = second_q ? S_IDLE : S_PRE_STEP;
        fin_ok = second_q && !refuse;
      end
      S_PRE_STEP: begin
        cmd  = DC_INC_MED;
        st_n = S_PRE_SMP;
      end
      S_PRE_SMP: if (smp_done) begin
        st_n    = smp_hi ? S_CO_SMP : S_IDLE;
        fin_bad = !smp_hi;
      end
      S_CO_SMP: if (smp_done) begin
        st_n     = smp_hi ? S_CO_STEP : S_MH_SMP;
        second_n = second_q || !smp_hi;
      end
      S_CO_STEP: begin
        cmd  = DC_DEC_CRS;
        st_n = S_CO_SMP;
      end
      default: st_n = S_IDLE;
    endcase
    if ((cmd != DC_NONE) && refuse) begin
      st_n    = S_IDLE;
      fin_bad = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      second_q   <= 1'b0;
      launched_q <= 1'b0;
    end else begin
      st_q       <= st_n;
      second_q   <= second_n;
      launched_q <= launched_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcv_en_q <= '0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else if (load) begin
      rcv_en_q <= NUM_LANES'(1) << start_lane;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else if (fin_ok) begin
      rcv_en_q <= '0;
      done_q   <= 1'b1;
    end else if (fin_bad) begin
      fail_q <= 1'b1;
    end
  end

  rcv_delay_ctr #(
    .CRS_W  (CRS_W),
    .TAP_MAX(TAP_MAX)
  ) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .load_crs(init_coarse),
    .load_med(load_med),
    .cmd     (cmd),
    .pi_set  (pi_set),
    .pi_val  (pi_val),
    .refuse  (refuse),
    .crs     (dly_coarse),
    .med     (dly_medium),
    .tap     (dly_tap),
    .pi      (dly_pi)
  );

  rcv_probe_seq #(
    .WAIT_W(WAIT_W)
  ) u_probe (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (probe_go),
    .rst_wait   (rst_wait),
    .rd_valid   (rd_valid),
    .rd_dqs     (rd_dqs),
    .probe_rst_n(probe_rst_n),
    .rd_req     (rd_req),
    .smp_done   (smp_done),
    .smp_hi     (smp_hi)
  );

  assign rcv_en = rcv_en_q;
  assign busy   = (st_q != S_IDLE);
  assign done   = done_q;
  assign fail   = fail_q;

endmodule

// File: rtl/rcv_cal_seq_chk.sv
module rcv_cal_seq_chk #(
  parameter int NUM_LANES = 8,
  parameter int CRS_W     = 4,
  parameter int TAP_MAX   = 14,
  localparam int TAP_W    = $clog2(TAP_MAX + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 probe_rst_n,
  input logic                 rd_req,
  input logic                 rd_valid,
  input logic [NUM_LANES-1:0] rcv_en,
  input logic [CRS_W-1:0]     dly_coarse,
  input logic [1:0]           dly_medium,
  input logic [TAP_W-1:0]     dly_tap,
  input logic [2:0]           dly_pi,
  input logic                 busy,
  input logic                 done,
  input logic                 fail
);

  // R3
  rd_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req);

  // R3
  probe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> probe_rst_n);

  // R4
  dly_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> $stable({dly_coarse, dly_medium, dly_tap, dly_pi}));

  // R6
  tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dly_tap <= TAP_W'(TAP_MAX));

  // R2
  lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(rcv_en) == 1);

  // R9
  done_rcv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rcv_en == '0);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req && probe_rst_n);

  // R12
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

endmodule

bind rcv_cal_seq rcv_cal_seq_chk #(
  .NUM_LANES(NUM_LANES),
  .CRS_W    (CRS_W),
  .TAP_MAX  (TAP_MAX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .probe_rst_n(probe_rst_n),
  .rd_req     (rd_req),
  .rd_valid   (rd_valid),
  .rcv_en     (rcv_en),
  .dly_coarse (dly_coarse),
  .dly_medium (dly_medium),
  .dly_tap    (dly_tap),
  .dly_pi     (dly_pi),
  .busy       (busy),
  .done       (done),
  .fail       (fail)
);

// File: tb/rcv_cal_seq_bench.sv
module rcv_cal_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NL     = 8;
  localparam int CRS_W  = 4;
  localparam int TAP_MX = 14;
  localparam int WAIT_W = 8;
  localparam int LW     = $clog2(NL);
  localparam int TW     = $clog2(TAP_MX + 1);

  logic              clk, rst_n, start, rd_valid, rd_dqs;
  logic [LW-1:0]     start_lane;
  logic [CRS_W-1:0]  init_coarse;
  logic [WAIT_W-1:0] rst_wait;
  logic              probe_rst_n, rd_req, busy, done, fail;
  logic [NL-1:0]     rcv_en;
  logic [CRS_W-1:0]  dly_coarse;
  logic [1:0]        dly_medium;
  logic [TW-1:0]     dly_tap;
  logic [2:0]        dly_pi;

  rcv_cal_seq #(.NUM_LANES(NL), .CRS_W(CRS_W), .TAP_MAX(TAP_MX), .WAIT_W(WAIT_W)) u_rcv_cal_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_lane(start_lane),
    .init_coarse(init_coarse), .rst_wait(rst_wait), .probe_rst_n(probe_rst_n),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_dqs(rd_dqs), .rcv_en(rcv_en),
    .dly_coarse(dly_coarse), .dly_medium(dly_medium), .dly_tap(dly_tap),
    .dly_pi(dly_pi), .busy(busy), .done(done), .fail(fail)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // strobe pattern seen by the probe, as a function of the linear delay position
  int per = 240, w0a = 100, w0b = 200, w1a = 0, w1b = 0;
  int lat = 1;
  int cur_lane = 0;

  function automatic bit dqs_at(int l);
    int r;
    r = l % per;
    return ((r >= w0a) && (r < w0b)) || ((r >= w1a) && (r < w1b));
  endfunction

  function automatic int enc(int c, int m, int t, int p);
    return (((c * 4 + m) * 16) + t) * 8 + p;
  endfunction

  // behavioural reference: search order written as plain integer steps
  int mc, mm, mt, mp;
  int exp_q[$];

  function automatic bit m_sample();
    exp_q.push_back(enc(mc, mm, mt, mp));
    return dqs_at((mc * 4 + mm) * 15 + mt);
  endfunction

  function automatic bit m_inc_med();
    if (mm < 3) mm++;
    else if (mc < 15) begin mm = 0; mc++; end
    else return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit m_dec_med();
    if (mm > 0) mm--;
    else if (mc > 0) begin mm = 3; mc--; end
    else return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit m_inc_tap();
    if (mt == 14) begin
      if (!m_inc_med()) return 1'b0;
      mt = 0;
    end else mt++;
    return 1'b1;
  endfunction

  function automatic bit m_dec_tap();
    if (mt == 0) begin
      if (!m_dec_med()) return 1'b0;
      mt = 14;
    end else mt--;
    return 1'b1;
  endfunction

  function automatic bit m_edge();
    while (!m_sample()) if (!m_inc_med()) return 1'b0;
    if (!m_dec_med()) return 1'b0;
    do begin
      if (!m_inc_tap()) return 1'b0;
    end while (!m_sample());
    return 1'b1;
  endfunction

  task automatic model_run(input int lane, input int c0, output bit ok);
    ok = 1'b0;
    mc = c0; mm = lane * 4 / NL; mt = 0; mp = 0;
    while (m_sample()) if (!m_inc_med()) return;
    if (!m_inc_med()) return;
    if (!m_edge()) return;
    if (!m_dec_tap()) return;
    mp = 3;
    if (!m_inc_med()) return;
    if (!m_sample()) return;
    while (m_sample()) begin
      if (mc == 0) return;
      mc--;
    end
    if (!m_edge()) return;
    if (!m_dec_tap()) return;
    mp = 7;
    ok = 1'b1;
  endtask

  // probe / memory responder
  int rcnt = 0;
  always @(negedge clk) begin
    if (!rst_n || !rd_req || rd_valid) begin
      rd_valid = 1'b0;
      rcnt = 0;
    end else if (rcnt >= lat) begin
      rd_valid = 1'b1;
      rd_dqs = dqs_at((int'(dly_coarse) * 4 + int'(dly_medium)) * 15 + int'(dly_tap));
      rcnt = 0;
    end else rcnt++;
  end

  // per-clock comparison against the reference
  int  lo_cnt = 0, hi_cnt = 0;
  bit  hi_track = 1'b0, req_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_req && !req_prev) begin
        if (exp_q.size() == 0) chk("R10", "sample beyond expected sequence", 1, 0);
        else chk("R4", "setting at sample (R5 R6 R7 R8)",
                 enc(dly_coarse, dly_medium, dly_tap, dly_pi), exp_q.pop_front());
      end
      req_prev = rd_req;
      if (!probe_rst_n) lo_cnt++;
      else begin
        if (lo_cnt != 0) begin
          chk("R3", "probe reset low cycles", lo_cnt, int'(rst_wait) + 1);
          lo_cnt = 0; hi_cnt = 0; hi_track = 1'b1;
        end
        if (hi_track) begin
          if (rd_req) begin
            chk("R3", "probe reset high cycles", hi_cnt, int'(rst_wait) + 1);
            hi_track = 1'b0;
          end else hi_cnt++;
        end
      end
      if (busy) chk("R2", "rcv_en during run", int'(rcv_en), 1 << cur_lane);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic run_case(input int lane, input int c0, input int wt, input int lt,
                          input bit stray, input string tag);
    bit ok;
    int fin;
    exp_q.delete();
    model_run(lane, c0, ok);
    fin = enc(mc, mm, mt, mp);
    lat = lt;
    cur_lane = lane;
    @(negedge clk);
    rst_wait = WAIT_W'(wt);
    start_lane = LW'(lane);
    init_coarse = CRS_W'(c0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "busy after start", int'(busy), 1);
    chk("R2", "loaded setting", enc(dly_coarse, dly_medium, dly_tap, dly_pi),
        enc(c0, lane * 4 / NL, 0, 0));
    if (stray) begin
      repeat (30) @(negedge clk);
      chk("R11", "busy before stray start", int'(busy), 1);
      start_lane = LW'(lane ^ 3);
      init_coarse = CRS_W'(c0 + 2);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    chk(tag, "done", int'(done), int'(ok));
    chk(tag, "fail", int'(fail), int'(!ok));
    chk(tag, "final setting", enc(dly_coarse, dly_medium, dly_tap, dly_pi), fin);
    chk(tag, "rcv_en at end", int'(rcv_en), ok ? 0 : (1 << lane));
    chk(tag, "unissued samples", exp_q.size(), 0);
    repeat (5) @(negedge clk);
    chk("R12", "outcome held", int'({done, fail}), ok ? 2 : 1);
    chk("R12", "setting held", enc(dly_coarse, dly_medium, dly_tap, dly_pi), fin);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; start_lane = '0; init_coarse = '0; rst_wait = '0;
    rd_valid = 1'b0; rd_dqs = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "done/fail after reset", int'({done, fail}), 0);
    chk("R1", "rd_req after reset", int'(rd_req), 0);
    chk("R1", "probe_rst_n after reset", int'(probe_rst_n), 1);
    chk("R1", "rcv_en after reset", int'(rcv_en), 0);

    // periodic strobe window: full two-edge success from a low start
    per = 240; w0a = 100; w0b = 200; w1a = 0; w1b = 0;
    run_case(0, 1, 2, 1, 1'b0, "R9");
    // other lane, zero wait, slower reads, medium roll-over into next coarse
    run_case(5, 3, 0, 3, 1'b0, "R9");
    // starts inside the high region: low search takes several steps (R5)
    run_case(7, 1, 1, 0, 1'b0, "R5");
    // start pulse during a run is ignored
    run_case(2, 1, 3, 2, 1'b1, "R11");
    // always high: medium runs out of range, refused step
    per = 100000; w0a = 0; w0b = 100000;
    run_case(0, 13, 0, 1, 1'b0, "R10");
    // narrow window: preamble check reads low
    per = 240; w0a = 100; w0b = 108;
    run_case(0, 1, 1, 1, 1'b0, "R7");
    // high down to coarse 0 during back-off
    per = 100000; w0a = 0; w0b = 125; w1a = 150; w1b = 400;
    run_case(0, 2, 1, 1, 1'b0, "R8");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule